// File: doc/BRIEF.md
# Dual-Channel Fault Detect and Swap

This block watches two unsigned magnitudes, one for each of two current-sensing channels, and decides which channel is used for billing. The magnitudes arrive with a sample strobe. On every strobe the block compares the inactive channel against the active one using ratio thresholds. It raises a fault flag when the two channels disagree. When the inactive channel is clearly the larger of the two and stays so, it hands billing over to that channel.

A drop of the inactive channel below seven-eighths of the active channel only raises the fault. A rise above about 114% of the active channel raises the fault at once. It also starts a persistence count, and the selection swaps only after that condition has held on `DELAY_SAMPLES` consecutive strobes. The fault clears as soon as the two magnitudes lie within 12.5% of each other in both directions. A swap back needs the original channel to exceed about 114% of the now-active one. The gap between these two conditions keeps the selection from chattering.

Top module: `chan_fault_swap`

## Requirements
- R1: After reset, activeSel is 0 (channel A active), faultFlag is 0 and swapPulse is 0.
- R2: On a strobe where the inactive magnitude is strictly below act - (act >> 3) (act = active magnitude), faultFlag is 1 from the next clock edge, and that strobe causes no swap.
- R3: On a strobe where the inactive magnitude is strictly above act + (act >> 3) + (act >> 6), faultFlag is 1 from the next clock edge, already on the first such strobe.
- R4: activeSel toggles (0 = A, 1 = B) at the clock edge of the DELAY_SAMPLES-th consecutive strobe meeting the R3 condition, and the persistence count then starts again from zero.
- R5: A strobe that does not meet the R3 condition restarts the persistence count, so that a later swap needs DELAY_SAMPLES fresh qualifying strobes.
- R6: After a swap, the selection returns only when the original channel, now the inactive one, meets the R3 condition against the now-active channel for DELAY_SAMPLES strobes. A moderate excess does not bring it back.
- R7: faultFlag clears on a strobe where neither R2 nor R3 applies and both inact >= act - (act >> 3) and act >= inact - (inact >> 3) hold. Otherwise it keeps its value.
- R8: swapPulse is 1 for exactly the one cycle after each clock edge at which activeSel changes, and 0 at all other times.
- R9: Cycles without a strobe change none of the outputs or the persistence count, whatever the magnitudes are.
- R10: When both magnitudes are zero, the channels count as matched: no fault and no swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Strobe: magA and magB are valid this cycle |
| magA | input | MAG_W | Magnitude of channel A |
| magB | input | MAG_W | Magnitude of channel B |
| activeSel | output | 1 | Billing channel, 0 = A, 1 = B |
| faultFlag | output | 1 | Channel disagreement flag |
| swapPulse | output | 1 | One-cycle pulse on each selection change |

## Verification
Two things happen on the same strobe: the swap and the fault decision. On the final qualifying strobe, the selection flips while the fault state is updated from the comparison against the pre-swap pairing. The bench provokes this by feeding a run of strobes above the 114% threshold that is split by idle cycles carrying extreme magnitudes. It then expects the pulse, the new selection and the fault level together on the cycle after that edge. A second collision comes on the strobe right after the swap, where the fault must be judged against the new pairing with no further pulse.

// File: rtl/fdsw_pkg.sv
package fdsw_pkg;
  // Comparison results from the datapath for the current pairing
  typedef struct packed {
    logic inactLow;   // inactive below 7/8 of active
    logic inactHigh;  // inactive above ~114% of active
    logic matched;    // both within 12.5% of each other
  } cmp_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic doSwap;
    logic setFault;
    logic clrFault;
  } ctl_t;
endpackage

// File: rtl/fdsw_datapath.sv
module fdsw_datapath
  import fdsw_pkg::*;
#(
  parameter int MAG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAG_W-1:0] magA,
  input  logic [MAG_W-1:0] magB,
  input  ctl_t             ctl,
  output cmp_t             cmp,
  output logic             activeSel,
  output logic             faultFlag,
  output logic             swapPulse
);
  localparam int EXT_W = MAG_W + 1;

  logic [EXT_W-1:0] actW, inactW, actLowThr, actHighThr, inactLowThr;

  always_comb begin
    actW        = activeSel ? EXT_W'(magB) : EXT_W'(magA);
    inactW      = activeSel ? EXT_W'(magA) : EXT_W'(magB);
    actLowThr   = actW - (actW >> 3);
    actHighThr  = actW + (actW >> 3) + (actW >> 6);
    inactLowThr = inactW - (inactW >> 3);
    cmp.inactLow  = inactW < actLowThr;
    cmp.inactHigh = inactW > actHighThr;
    cmp.matched   = (inactW >= actLowThr) && (actW >= inactLowThr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      activeSel <= 1'b0;
      faultFlag <= 1'b0;
      swapPulse <= 1'b0;
    end else begin
      swapPulse <= ctl.doSwap;
      if (ctl.doSwap) activeSel <= ~activeSel;
      if (ctl.setFault)      faultFlag <= 1'b1;
      else if (ctl.clrFault) faultFlag <= 1'b0;
    end
  end

  // R8: a pulse always accompanies a selection change, and vice versa
  assert_pulse_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    swapPulse |-> (activeSel != $past(activeSel)));
  assert_sel_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !swapPulse |-> $stable(activeSel));
  // R9: without strobes from control nothing moves
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == '0) |=> ($stable(faultFlag) && !swapPulse));
  // R2/R3: a raise strobe leaves the flag set
  assert_fault_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.setFault |=> faultFlag);
endmodule

// File: rtl/fdsw_control.sv
module fdsw_control
  import fdsw_pkg::*;
#(
  parameter int DELAY_SAMPLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sampleValid,
  input  cmp_t cmp,
  output ctl_t ctl
);
  localparam int CNT_W = (DELAY_SAMPLES < 2) ? 1 : $clog2(DELAY_SAMPLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_SAMPLES - 1);

  logic [CNT_W-1:0] persistCnt;

  always_comb begin
    ctl.doSwap   = sampleValid && cmp.inactHigh && (persistCnt == LAST);
    ctl.setFault = sampleValid && (cmp.inactLow || cmp.inactHigh);
    ctl.clrFault = sampleValid && cmp.matched;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      persistCnt <= '0;
    end else if (sampleValid) begin
      if (!cmp.inactHigh || ctl.doSwap) persistCnt <= '0;
      else                              persistCnt <= persistCnt + 1'b1;
    end
  end

  // R4: count never passes the qualification limit
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    persistCnt <= LAST);
  // R5: a non-qualifying strobe restarts the count
  assert_cnt_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleValid && !cmp.inactHigh) |=> (persistCnt == '0));
  // R9: idle cycles hold the count
  assert_cnt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleValid |=> $stable(persistCnt));
  // R2: a low excursion never swaps
  assert_no_swap_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmp.inactLow |-> !ctl.doSwap);
endmodule

// File: rtl/chan_fault_swap.sv
module chan_fault_swap
  import fdsw_pkg::*;
#(
  parameter int MAG_W         = 16,
  parameter int DELAY_SAMPLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sampleValid,
  input  logic [MAG_W-1:0] magA,
  input  logic [MAG_W-1:0] magB,
  output logic             activeSel,
  output logic             faultFlag,
  output logic             swapPulse
);
  cmp_t cmp;
  ctl_t ctl;

  fdsw_datapath #(.MAG_W(MAG_W)) uData (
    .clk(clk), .rst_n(rst_n), .magA(magA), .magB(magB), .ctl(ctl),
    .cmp(cmp), .activeSel(activeSel), .faultFlag(faultFlag), .swapPulse(swapPulse)
  );

  fdsw_control #(.DELAY_SAMPLES(DELAY_SAMPLES)) uCtrl (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .cmp(cmp), .ctl(ctl)
  );
endmodule

// File: tb/tb_chan_fault_swap.sv
module tb_chan_fault_swap;
  localparam int MAG_W = 16;
  localparam int DELAY = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sampleValid = 1'b0;
  logic [MAG_W-1:0] magA = '0, magB = '0;
  logic activeSel, faultFlag, swapPulse;

  chan_fault_swap #(.MAG_W(MAG_W), .DELAY_SAMPLES(DELAY)) dut (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .magA(magA), .magB(magB),
    .activeSel(activeSel), .faultFlag(faultFlag), .swapPulse(swapPulse)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic  sel;
    logic  fault;
    logic  pulse;
    string tag;
  } exp_t;

  exp_t expQ[$];
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // Reference model state
  logic mSel = 0, mFault = 0;
  int   mCnt = 0;

  task automatic pushExp(logic pulse, string tag);
    exp_t e;
    e.sel = mSel; e.fault = mFault; e.pulse = pulse; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic applySample(int a, int b, string tag);
    int act, inact, lowA, highA, lowI;
    logic isLow, isHigh, isMatch, pulse;
    @(negedge clk);
    magA = MAG_W'(a); magB = MAG_W'(b); sampleValid = 1'b1;
    act = mSel ? b : a;
    inact = mSel ? a : b;
    lowA = act - (act >> 3);
    highA = act + (act >> 3) + (act >> 6);
    lowI = inact - (inact >> 3);
    isLow = inact < lowA;
    isHigh = inact > highA;
    isMatch = (inact >= lowA) && (act >= lowI);
    pulse = 1'b0;
    if (isHigh) begin
      if (mCnt == DELAY - 1) begin mSel = ~mSel; pulse = 1'b1; mCnt = 0; end
      else mCnt++;
    end else mCnt = 0;
    if (isLow || isHigh) mFault = 1'b1;
    else if (isMatch)    mFault = 1'b0;
    @(posedge clk); #1;
    sampleValid = 1'b0;
    pushExp(pulse, tag);
  endtask

  task automatic idleCycles(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      magA = (i % 2 == 0) ? 16'd60000 : 16'd3;
      magB = (i % 2 == 0) ? 16'd2 : 16'd65535;
      @(posedge clk); #1;
      pushExp(1'b0, tag);
    end
  endtask

  // Monitor: pops one expectation per cycle, away from the active edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      nChecks++;
      if (activeSel !== e.sel || faultFlag !== e.fault || swapPulse !== e.pulse) begin
        nFails++;
        $display("FAIL %s: got sel=%b fault=%b pulse=%b, expected sel=%b fault=%b pulse=%b",
                 e.tag, activeSel, faultFlag, swapPulse, e.sel, e.fault, e.pulse);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    nChecks++;
    if (activeSel !== 1'b0 || faultFlag !== 1'b0 || swapPulse !== 1'b0) begin
      nFails++;
      $display("FAIL R1 reset: got sel=%b fault=%b pulse=%b, expected 0 0 0",
               activeSel, faultFlag, swapPulse);
    end

    applySample(1000, 1000, "R7 equal magnitudes");
    applySample(0, 0, "R10 both zero");
    applySample(1000, 874, "R2 just below 7/8");
    applySample(1000, 874, "R2 low held, no swap");
    applySample(1000, 875, "R7 clear at 7/8 boundary");
    applySample(1000, 1141, "R3 just above high threshold");
    applySample(1000, 1141, "R3 second qualifying strobe");
    applySample(1000, 1140, "R5 at threshold restarts count");
    applySample(1000, 1200, "R4 qualifying 1");
    applySample(1000, 1200, "R4 qualifying 2");
    applySample(1000, 1200, "R4 qualifying 3");
    idleCycles(3, "R9 idle with extreme magnitudes");
    applySample(1000, 1200, "R4 R8 fourth strobe swaps to B");
    applySample(1000, 1200, "R8 no second pulse, R2 fault vs new pairing");
    for (int i = 0; i < 5; i++) applySample(1300, 1200, "R6 moderate excess, no swap back");
    for (int i = 0; i < 4; i++) applySample(1400, 1200, "R6 R8 swap back to A");
    applySample(1000, 1000, "R7 clear after swap back");
    idleCycles(2, "R9 idle after clear");
    applySample(0, 0, "R10 zero again");

    while (expQ.size() > 0) @(posedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule